// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This engine takes frames from the receive side of an Ethernet MAC and stores each one in a memory buffer. Software owns a circular ring of four-word descriptors in memory and hands each descriptor to the engine by setting its ownership bit. When a frame begins, the engine reads the current descriptor. It fills that descriptor's buffer with the frame bytes, packed little-endian into 32-bit words. It then writes back the byte count and a status word that clears the ownership bit, and follows the descriptor's next-pointer word to the next entry in the ring.

Frame bytes arrive as a byte stream with start, end and error markers, and the stream is paced by a ready signal. Memory is reached through a word-addressed request/acknowledge master port. Optionally, two zero bytes are placed ahead of each frame so that the IP header after the 14-byte Ethernet header starts on a word boundary.

A small register write port sets:
- the current descriptor pointer;
- a command word with a receive-enable bit and an abort bit;
- an interrupt mask;
- write-one-to-clear interrupt cause bits.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, `cur_ptr` is 0, the receive-enable and abort bits read 0, `cause` is 0, `irq` is 0 and no memory request is raised.
- R2: A descriptor is four words at the byte address in `cur_ptr`: +0 status, +1 count/size (count in bits 15:0, buffer size in bits 31:16), +2 buffer byte pointer, +3 next-descriptor byte pointer. A frame is stored only if status bit 31 (owned by the engine) reads 1.
- R3: Frame byte k is written to byte lane k mod 4 (bits 8*lane+7:8*lane) of the buffer word at word address (buffer pointer / 4) + k / 4. In the final partial word, lanes beyond the stored count are 0. Buffer words past the stored bytes are not written.
- R4: When `stuff_en` is 1, two zero bytes precede the frame in the buffer and are included in the reported byte count.
- R5: On completion, word +1 receives {buffer size, stored count}. Word +0 is then written as the last write of the frame, with bit 31 = 0, bits 17 and 16 = 1, bit 23 copied from the fetched status and bit 15 = error. All other bits are 0.
- R6: After the status write, the engine reads word +3 and loads it into `cur_ptr`.
- R7: If the descriptor is not owned when a frame starts, the whole frame is consumed and discarded. Memory is not written, `cur_ptr` is unchanged and cause bit 8 is set.
- R8: Stored bytes (stuffing included) never exceed the buffer size. Excess bytes are discarded and set the error bit. A frame that exactly fills the buffer is not an error.
- R9: An error marker on the end byte sets status bit 15 and cause bit 8. The frame data is still stored.
- R10: With command bit 7 (receive enable) at 0, arriving frames are consumed and discarded without any descriptor access.
- R11: Writing command bit 15 sets the abort bit. An engine waiting between data bytes abandons its frame and goes idle; the descriptor stays owned and `cur_ptr` is unchanged. The abort bit is cleared by hardware only while the engine is idle. Bytes that arrive before the next frame start are discarded.
- R12: Cause bit 0 is set when a descriptor with status bit 23 set is completed, and cause bit 8 is set on any error. Writing 1s to the cause register clears those bits. `irq` is 1 when any cause bit is set whose mask bit is also set. Register select values: 0 = current pointer, 1 = command, 2 = mask, 3 = cause.
- R13: A memory request holds its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select (0 pointer, 1 command, 2 mask, 3 cause) |
| csr_wdata | input | 32 | Register write data |
| stuff_en | input | 1 | Place two zero bytes ahead of each frame |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Stream byte accepted |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_err | input | 1 | Frame error, valid with last byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| cur_ptr | output | 32 | Current descriptor byte pointer |
| rx_en | output | 1 | Receive-enable command bit |
| abort_pend | output | 1 | Abort command bit |
| cause | output | 32 | Interrupt cause (bits 0 and 8) |
| irq | output | 1 | Masked interrupt |

## Verification
The results of a frame follow the last byte after one data-word write, the count write, the status write and the next-pointer read. Each of these takes at most the memory latency plus two cycles. The bench therefore waits a fixed 40 cycles after the end byte before it inspects memory, `cur_ptr`, `cause` and `irq`. A register write is visible at the falling edge after its rising edge. The bench samples the abort bit there, when it has just been set, and again one cycle later, when an idle engine must have cleared it. All outputs are sampled on falling edges, and memory latency cycles through 0 to 2 wait cycles across the sweep.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 4;
  localparam int CNT_W   = 16;
  localparam int OWN_BIT = 31;
  localparam int IE_BIT  = 23;
  localparam int FST_BIT = 17;
  localparam int LST_BIT = 16;
  localparam int ERR_BIT = 15;
  localparam int CMD_EN_BIT  = 7;
  localparam int CMD_ABT_BIT = 15;
  localparam int CS_DONE_BIT = 0;
  localparam int CS_ERR_BIT  = 8;
  localparam logic [1:0] W_STS  = 2'd0;
  localparam logic [1:0] W_CNT  = 2'd1;
  localparam logic [1:0] W_BUF  = 2'd2;
  localparam logic [1:0] W_NEXT = 2'd3;

  typedef enum logic [1:0] {
    CSR_CUR = 2'd0, CSR_CMD = 2'd1, CSR_MASK = 2'd2, CSR_CAUSE = 2'd3
  } csr_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_STS, ST_RD_SIZE, ST_RD_BUF, ST_DATA,
    ST_WR_DATA, ST_WR_CNT, ST_WR_STS, ST_RD_NEXT, ST_DROP
  } rxd_state_e;
endpackage

// File: rtl/rxd_csr.sv
module rxd_csr
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic              wd_en,
  input  logic              wd_abt,
  input  logic              wd_done,
  input  logic              wd_err,
  input  logic              eng_idle,
  input  logic              set_done,
  input  logic              set_err,
  output logic              rx_en,
  output logic              abort_pend,
  output logic [WORD_W-1:0] cause,
  output logic              irq
);
  logic en_q, en_d, ab_q, ab_d;
  logic cd_q, cd_d, ce_q, ce_d, md_q, md_d, me_q, me_d;

  always_comb begin
    en_d = en_q;
    ab_d = ab_q;
    cd_d = cd_q;
    ce_d = ce_q;
    md_d = md_q;
    me_d = me_q;
    if (csr_we && csr_sel == CSR_CMD) begin
      en_d = wd_en;
      if (wd_abt) ab_d = 1'b1;
    end else if (ab_q && eng_idle) begin
      ab_d = 1'b0;
    end
    if (csr_we && csr_sel == CSR_MASK) begin
      md_d = wd_done;
      me_d = wd_err;
    end
    if (csr_we && csr_sel == CSR_CAUSE) begin
      if (wd_done) cd_d = 1'b0;
      if (wd_err)  ce_d = 1'b0;
    end
    if (set_done) cd_d = 1'b1;
    if (set_err)  ce_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ab_q <= 1'b0;
      cd_q <= 1'b0;
      ce_q <= 1'b0;
      md_q <= 1'b0;
      me_q <= 1'b0;
    end else begin
      en_q <= en_d;
      ab_q <= ab_d;
      cd_q <= cd_d;
      ce_q <= ce_d;
      md_q <= md_d;
      me_q <= me_d;
    end
  end

  always_comb begin
    cause = '0;
    cause[CS_DONE_BIT] = cd_q;
    cause[CS_ERR_BIT]  = ce_q;
  end

  assign rx_en      = en_q;
  assign abort_pend = ab_q;
  assign irq        = (cd_q & md_q) | (ce_q & me_q);

  // R11: the abort bit falls only when the engine was idle
  a_r11_abort_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ab_q) |-> $past(eng_idle));

  // R12: a cause bit rises only in a cycle where hardware reported the event
  a_r12_done_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cd_q) |-> $past(set_done));
endmodule

// File: rtl/rxd_pack.sv
module rxd_pack #(
  parameter int LANES = 4,
  localparam int LW   = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr,
  input  logic [LW-1:0]      lane,
  input  logic [7:0]         din,
  output logic [8*LANES-1:0] word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] q, d;
    always_comb begin
      d = q;
      if (clr) d = '0;
      if (wr && lane == LW'(g)) d = din;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign word[8*g +: 8] = q;
  end
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rxd_pkg::*;
#(
  parameter int STUFF_N = 2,
  localparam int AW     = WORD_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [WORD_W-1:0] csr_wdata,
  input  logic              stuff_en,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [WORD_W-1:0] cur_ptr,
  output logic              rx_en,
  output logic              abort_pend,
  output logic [WORD_W-1:0] cause,
  output logic              irq
);
  rxd_state_e        st_q, st_d;
  logic [WORD_W-1:0] cur_q, cur_d;
  logic [AW-1:0]     buf_q, buf_d, waddr_q, waddr_d, cur_w;
  logic [CNT_W-1:0]  size_q, size_d, cnt_q, cnt_d;
  logic              ie_q, ie_d, err_q, err_d, done_q, done_d;
  logic              pk_clr, pk_wr, set_done, set_err;
  logic [WORD_W-1:0] pk_word, sts;
  logic              room;

  rxd_csr u_csr (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .wd_en(csr_wdata[CMD_EN_BIT]), .wd_abt(csr_wdata[CMD_ABT_BIT]),
    .wd_done(csr_wdata[CS_DONE_BIT]), .wd_err(csr_wdata[CS_ERR_BIT]),
    .eng_idle(st_q == ST_IDLE), .set_done(set_done), .set_err(set_err),
    .rx_en(rx_en), .abort_pend(abort_pend), .cause(cause), .irq(irq)
  );

  rxd_pack #(.LANES(LANES)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .wr(pk_wr),
    .lane(cnt_q[1:0]), .din(rx_data), .word(pk_word)
  );

  assign cur_w = cur_q[WORD_W-1:2];
  assign room  = cnt_q < size_q;

  always_comb begin
    sts = '0;
    sts[IE_BIT]  = ie_q;
    sts[FST_BIT] = 1'b1;
    sts[LST_BIT] = 1'b1;
    sts[ERR_BIT] = err_q;
  end

  // next-state and datapath
  always_comb begin
    st_d = st_q;  cur_d = cur_q;  buf_d = buf_q;  size_d = size_q;
    cnt_d = cnt_q;  ie_d = ie_q;  err_d = err_q;  done_d = done_q;
    waddr_d = waddr_q;
    pk_clr = 1'b0;  pk_wr = 1'b0;  set_done = 1'b0;  set_err = 1'b0;
    rx_ready = 1'b0;
    if (csr_we && csr_sel == CSR_CUR) cur_d = csr_wdata;
    unique case (st_q)
      ST_IDLE: begin
        rx_ready = rx_valid && !(rx_sof && rx_en);
        if (rx_valid && rx_sof && rx_en && !abort_pend) st_d = ST_RD_STS;
      end
      ST_RD_STS: if (mem_ack) begin
        if (mem_rdata[OWN_BIT]) begin
          ie_d = mem_rdata[IE_BIT];
          st_d = ST_RD_SIZE;
        end else begin
          set_err = 1'b1;
          st_d    = ST_DROP;
        end
      end
      ST_RD_SIZE: if (mem_ack) begin
        size_d = mem_rdata[WORD_W-1:CNT_W];
        st_d   = ST_RD_BUF;
      end
      ST_RD_BUF: if (mem_ack) begin
        buf_d  = mem_rdata[WORD_W-1:2];
        cnt_d  = stuff_en ? CNT_W'(STUFF_N) : '0;
        pk_clr = 1'b1;
        err_d  = 1'b0;
        done_d = 1'b0;
        st_d   = ST_DATA;
      end
      ST_DATA: begin
        if (abort_pend) begin
          st_d = ST_IDLE;
        end else begin
          rx_ready = rx_valid;
          if (rx_valid) begin
            if (rx_eof) begin
              err_d  = err_q | rx_err;
              done_d = 1'b1;
            end
            if (room) begin
              pk_wr   = 1'b1;
              cnt_d   = cnt_q + CNT_W'(1);
              waddr_d = buf_q + AW'(cnt_q >> 2);
              if (cnt_q[1:0] == 2'd3 || rx_eof || cnt_q + CNT_W'(1) == size_q)
                st_d = ST_WR_DATA;
            end else begin
              err_d = 1'b1;
              if (rx_eof) st_d = ST_WR_CNT;
            end
          end
        end
      end
      ST_WR_DATA: if (mem_ack) begin
        pk_clr = 1'b1;
        st_d   = done_q ? ST_WR_CNT : ST_DATA;
      end
      ST_WR_CNT: if (mem_ack) st_d = ST_WR_STS;
      ST_WR_STS: if (mem_ack) begin
        set_done = ie_q;
        set_err  = err_q;
        st_d     = ST_RD_NEXT;
      end
      ST_RD_NEXT: if (mem_ack) begin
        cur_d = mem_rdata;
        st_d  = ST_IDLE;
      end
      ST_DROP: begin
        if (abort_pend) begin
          st_d = ST_IDLE;
        end else begin
          rx_ready = rx_valid;
          if (rx_valid && rx_eof) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // memory master
  always_comb begin
    mem_req = 1'b0;  mem_we = 1'b0;  mem_addr = cur_w;  mem_wdata = '0;
    unique case (st_q)
      ST_RD_STS:  begin mem_req = 1'b1; mem_addr = cur_w + AW'(W_STS);  end
      ST_RD_SIZE: begin mem_req = 1'b1; mem_addr = cur_w + AW'(W_CNT);  end
      ST_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_w + AW'(W_BUF);  end
      ST_RD_NEXT: begin mem_req = 1'b1; mem_addr = cur_w + AW'(W_NEXT); end
      ST_WR_DATA: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = waddr_q; mem_wdata = pk_word;
      end
      ST_WR_CNT: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_w + AW'(W_CNT);
        mem_wdata = {size_q, cnt_q};
      end
      ST_WR_STS: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_w + AW'(W_STS);
        mem_wdata = sts;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cur_q <= '0;  buf_q <= '0;  size_q <= '0;
      cnt_q <= '0;  ie_q <= 1'b0;  err_q <= 1'b0;  done_q <= 1'b0;
      waddr_q <= '0;
    end else begin
      st_q <= st_d;  cur_q <= cur_d;  buf_q <= buf_d;  size_q <= size_d;
      cnt_q <= cnt_d;  ie_q <= ie_d;  err_q <= err_d;  done_q <= done_d;
      waddr_q <= waddr_d;
    end
  end

  assign cur_ptr = cur_q;

  // R13: an unacknowledged request does not move
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R5: a write to the status word never hands ownership back to the engine
  a_r5_status_releases: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_addr == cur_w |-> !mem_wdata[OWN_BIT]);

  // R5: the status write directly follows the count write
  a_r5_status_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_WR_STS) |-> $past(st_q) == ST_WR_CNT);

  // R8: a byte arriving at a full buffer does not grow the count
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_DATA && !abort_pend && rx_valid && !room |=> cnt_q == $past(cnt_q));

  // R6: the pointer moves only on a next-pointer read or a register write
  a_r6_ptr_source: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q != $past(cur_q) |->
      ($past(st_q == ST_RD_NEXT && mem_ack) || $past(csr_we && csr_sel == CSR_CUR)));
endmodule

// File: tb/rx_ring_dma_tb.sv
module rx_ring_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_we;
  logic [1:0]  csr_sel;
  logic [31:0] csr_wdata;
  logic        stuff_en;
  logic        rx_valid, rx_ready, rx_sof, rx_eof, rx_err;
  logic [7:0]  rx_data;
  logic        mem_req, mem_we, mem_ack;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] cur_ptr, cause;
  logic        rx_en, abort_pend, irq;

  logic [31:0] mem [256];
  int          lat, wcnt;
  int          n_chk = 0, n_fail = 0;
  int          ring = 0;
  logic [31:0] mask_v = 32'h0;
  bit          done_flag = 0;

  always #10 clk = ~clk;

  rx_ring_dma u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .stuff_en(stuff_en), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .cur_ptr(cur_ptr), .rx_en(rx_en), .abort_pend(abort_pend), .cause(cause), .irq(irq)
  );

  // memory model: acknowledge after lat wait cycles, one-cycle ack pulse
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[7:0]];
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(logic [1:0] s, logic [31:0] d);
    csr_we = 1'b1; csr_sel = s; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic put_byte(logic [7:0] d, bit sof, bit eof, bit err);
    rx_valid = 1'b1; rx_data = d; rx_sof = sof; rx_eof = eof; rx_err = err;
    #1;
    while (!rx_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
  endtask

  function automatic int d_word(int k); return k * 4; endfunction
  function automatic int b_word(int k); return 64 + k * 32; endfunction

  task automatic prep_desc(int k, bit own, bit ie, int size);
    mem[d_word(k)]     = {own, 7'd0, ie, 23'd0};
    mem[d_word(k) + 1] = {16'(size), 16'hABCD};
    mem[d_word(k) + 2] = 32'(b_word(k) * 4);
    mem[d_word(k) + 3] = 32'(((k + 1) % 3) * 16);
    for (int i = 0; i < 32; i++) mem[b_word(k) + i] = 32'hDEADBEEF;
  endtask

  function automatic logic [31:0] exp_word(int w, int n, int st, int base);
    logic [31:0] r = '0;
    for (int l = 0; l < 4; l++) begin
      int j = w * 4 + l;
      if (j < n && j >= st) r[l*8 +: 8] = 8'(base + j - st);
    end
    return r;
  endfunction

  task automatic run_frame(int len, bit err, bit stf, int size, bit ie, int base);
    int st = stf ? 2 : 0;
    int n  = (len + st > size) ? size : len + st;
    bit xe = err || (len + st > size);
    int nw = (n + 3) / 4;
    prep_desc(ring, 1'b1, ie, size);
    stuff_en = stf;
    for (int i = 0; i < len; i++) put_byte(8'(base + i), i == 0, i == len - 1, err && (i == len - 1));
    repeat (40) @(negedge clk);
    for (int w = 0; w < nw; w++)
      chk(stf ? "R4 buffer word" : "R3 buffer word", mem[b_word(ring) + w], exp_word(w, n, st, base));
    chk(xe ? "R8 word past data" : "R3 word past data", mem[b_word(ring) + nw], 32'hDEADBEEF);
    chk("R5 count word", mem[d_word(ring) + 1], {16'(size), 16'(n)});
    chk(err ? "R9 status word" : "R5 status word", mem[d_word(ring)],
        {8'd0, ie, 5'd0, 2'b11, xe, 15'd0});
    chk("R6 next pointer", cur_ptr, 32'(((ring + 1) % 3) * 16));
    chk("R12 cause", cause, {23'd0, xe, 7'd0, ie});
    chk("R12 irq", {31'd0, irq}, {31'd0, (ie & mask_v[0]) | (xe & mask_v[8])});
    csr_wr(2'd3, 32'hFFFF_FFFF);
    chk("R12 cause cleared", cause, 32'h0);
    ring = (ring + 1) % 3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_we = 1'b0; csr_sel = '0; csr_wdata = '0; stuff_en = 1'b0;
    rx_valid = 1'b0; rx_data = '0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0; lat = 0; wcnt = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cur_ptr", cur_ptr, 32'h0);
    chk("R1 enable", {31'd0, rx_en}, 32'h0);
    chk("R1 abort", {31'd0, abort_pend}, 32'h0);
    chk("R1 cause", cause, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'h0);

    csr_wr(2'd0, 32'h0);
    mask_v = 32'h101;
    csr_wr(2'd2, mask_v);
    csr_wr(2'd1, 32'h80);
    chk("R10 enable bit", {31'd0, rx_en}, 32'h1);

    // R2/R3/R4 sweep over lengths, stuffing, latency
    for (int s = 0; s < 2; s++)
      for (int len = 1; len <= 12; len++) begin
        lat = len % 3;
        run_frame(len, len == 7, s[0], 64, len[0], 16 * len + s);
      end

    // R8 truncation and exact fit with stuffing
    for (int sz = 4; sz <= 10; sz++) begin
      lat = sz % 3;
      run_frame(8, 1'b0, 1'b1, sz, 1'b1, 8'h30 + sz);
    end

    // R12 mask off: no interrupt
    mask_v = 32'h0;
    csr_wr(2'd2, mask_v);
    run_frame(5, 1'b1, 1'b0, 64, 1'b1, 8'h77);
    mask_v = 32'h101;
    csr_wr(2'd2, mask_v);

    // R7 descriptor not owned
    prep_desc(ring, 1'b0, 1'b1, 64);
    for (int i = 0; i < 6; i++) put_byte(8'(i), i == 0, i == 5, 1'b0);
    repeat (20) @(negedge clk);
    chk("R7 status untouched", mem[d_word(ring)], 32'h0080_0000);
    chk("R7 count untouched", mem[d_word(ring) + 1], 32'h0040_ABCD);
    chk("R7 buffer untouched", mem[b_word(ring)], 32'hDEADBEEF);
    chk("R7 pointer held", cur_ptr, 32'(ring * 16));
    chk("R7 error cause", cause, 32'h100);
    chk("R12 irq on error", {31'd0, irq}, 32'h1);
    csr_wr(2'd3, 32'h100);
    chk("R12 cause cleared", cause, 32'h0);

    // R10 receive disabled
    csr_wr(2'd1, 32'h0);
    prep_desc(ring, 1'b1, 1'b1, 64);
    for (int i = 0; i < 5; i++) put_byte(8'(i), i == 0, i == 4, 1'b0);
    repeat (20) @(negedge clk);
    chk("R10 status untouched", mem[d_word(ring)], 32'h8080_0000);
    chk("R10 buffer untouched", mem[b_word(ring)], 32'hDEADBEEF);
    chk("R10 pointer held", cur_ptr, 32'(ring * 16));
    chk("R10 no cause", cause, 32'h0);
    csr_wr(2'd1, 32'h80);

    // R11 abort while idle
    csr_wr(2'd1, 32'h8080);
    chk("R11 abort set", {31'd0, abort_pend}, 32'h1);
    @(negedge clk);
    chk("R11 abort cleared", {31'd0, abort_pend}, 32'h0);
    chk("R11 enable kept", {31'd0, rx_en}, 32'h1);

    // R11 abort in the middle of a frame
    stuff_en = 1'b0;
    prep_desc(ring, 1'b1, 1'b1, 64);
    for (int i = 0; i < 3; i++) put_byte(8'(i), i == 0, 1'b0, 1'b0);
    csr_wr(2'd1, 32'h8080);
    repeat (4) @(negedge clk);
    chk("R11 abort cleared after frame abandon", {31'd0, abort_pend}, 32'h0);
    for (int i = 3; i < 8; i++) put_byte(8'(i), 1'b0, i == 7, 1'b0);
    repeat (20) @(negedge clk);
    chk("R11 descriptor still owned", mem[d_word(ring)], 32'h8080_0000);
    chk("R11 pointer held", cur_ptr, 32'(ring * 16));
    chk("R11 no cause", cause, 32'h0);

    // the abandoned descriptor is used by the next frame
    lat = 1;
    run_frame(6, 1'b0, 1'b1, 64, 1'b1, 8'hA0);

    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule